// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels of the classic byte-wide microcontroller kind. Each channel keeps a low byte and a high byte of count state, a run bit, a gate bit, a mode code and an overflow flag. An external gate input per channel lets a level outside the block stretch or stop counting, which suits pulse width measurement. A single `tick` input is the shared count enable; clock source selection is done outside the block.

A 3-bit mode code per channel selects one of four modes. The first is a 13-bit counter whose low 5 bits act as a divide-by-32 prescaler. The second is a 16-bit cascaded counter. The third is an 8-bit counter that reloads from the high byte. The fourth, on channel 0 only, is a split mode with two independent 8-bit counters. In split mode, channel 0's high byte runs from channel 1's run bit and drives channel 1's flag, while channel 1 stands still. The low two mode bits and both gate bits share one register. The top mode bit of each channel lives in a separate auxiliary register. The remaining codes are reserved, and a channel set to one of them does nothing.

Software reaches everything through a plain register write port and a combinational read port. The overflow flags are also brought out on pins, and each flag has its own acknowledge input.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset every register reads 0 and both `ovf_flag` bits are 0.
- R2: A channel advances on a cycle only when `tick` is 1, its run bit is 1, and either its gate bit is 0 or its `gate_in` bit is 1. Otherwise its count holds.
- R3: Mode code 000 forms a 13-bit counter. Bits 4:0 of the low byte are a prescaler that carries into the high byte. Bits 7:5 of the low byte keep whatever was written. The flag is set when the high byte is 0xFF, the prescaler is 0x1F and the channel advances.
- R4: Mode code 001 forms a 16-bit counter from {high, low}. The flag is set when it wraps from 0xFFFF to 0x0000.
- R5: Mode code 010 counts the low byte. When the low byte advances past 0xFF it is loaded with the high byte and the flag is set. The high byte is unchanged.
- R6: Mode code 011 on channel 0 splits it. The low byte is an 8-bit counter under channel 0's run, gate and flag. The high byte counts on `tick` when channel 1's run bit is 1, with no gating, and sets channel 1's flag when it passes 0xFF. While channel 0 is in this mode channel 1 holds its count. Channel 1 set to 011 also holds.
- R7: Mode codes 100, 101, 110 and 111 hold the channel's count and never set its flag.
- R8: A flag is set on its overflow. It is cleared by writing 0 to its control bit or by a 1 on its `flag_ack` bit. An overflow in the same cycle wins over both.
- R9: A register write to a channel's byte loads that byte on the next edge. In modes 000, 001 and 010 a write to either byte of the channel suppresses that cycle's advance and overflow. In split mode a write blocks only the byte it targets.
- R10: The register map is as follows. Addresses 0 and 1 hold channel 0's low and high byte, and addresses 2 and 3 hold channel 1's. Address 4 is the mode register: channel 0 mode bits 1:0 in bits 1:0, channel 0 gate in bit 3, channel 1 mode bits 1:0 in bits 5:4, channel 1 gate in bit 7. Address 5 is the auxiliary register: channel 0 mode bit 2 in bit 0, channel 1 mode bit 2 in bit 4. Address 6 is control: run0 in bit 0, run1 in bit 1, flag0 in bit 2, flag1 in bit 3. Unused bits and address 7 read 0.
- R11: Writing the run bit to 1 leaves the count registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| tick | input | 1 | Shared count enable |
| gate_in | input | 2 | External gate level per channel |
| flag_ack | input | 2 | Flag clear pulse per channel |
| ovf_flag | output | 2 | Overflow flag per channel |

## Verification
The bench builds the block with its defaults: an 8-bit byte width and a 5-bit prescaler. At those values the 13-bit and 16-bit rollovers take 8192 and 65536 advances. The bench reaches them by loading counts of 0xFF and just below through the write port. A behavioural model, written with integers, is compared on every cycle against one rotating register read and both flag pins. Directed phases cover each mode, the gate, the acknowledge races and the write collisions. A long mixed phase then changes modes under running counts.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam logic [2:0] MODE_PRE = 3'b000;
  localparam logic [2:0] MODE_CAS = 3'b001;
  localparam logic [2:0] MODE_RLD = 3'b010;
  localparam logic [2:0] MODE_SPL = 3'b011;

  localparam int unsigned ADR_LO0  = 0;
  localparam int unsigned ADR_HI0  = 1;
  localparam int unsigned ADR_LO1  = 2;
  localparam int unsigned ADR_HI1  = 3;
  localparam int unsigned ADR_MODE = 4;
  localparam int unsigned ADR_AUX  = 5;
  localparam int unsigned ADR_CTRL = 6;

  typedef struct packed {
    logic [2:0] mode;
    logic       gate;
    logic       run;
    logic       flag;
  } chan_cfg_t;
endpackage

// File: rtl/dtu_chan.sv
module dtu_chan
  import dtu_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PRE_W    = 5,
  parameter bit          SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              cnt_en,
  input  logic              hi_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_own,
  output logic              ovf_alt
);
  localparam int unsigned WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [PRE_W:0]    pre_sum;
  logic [WIDE_W:0]   wide_sum;
  logic [BYTE_W:0]   lo_sum, hi_sum;
  logic              frozen;

  always_comb begin
    pre_sum  = {1'b0, lo_q[PRE_W-1:0]} + (PRE_W+1)'(1);
    wide_sum = {1'b0, hi_q, lo_q} + (WIDE_W+1)'(1);
    lo_sum   = {1'b0, lo_q} + (BYTE_W+1)'(1);
    hi_sum   = {1'b0, hi_q} + (BYTE_W+1)'(1);
    frozen   = wr_lo | wr_hi;
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_own  = 1'b0;
    ovf_alt  = 1'b0;
    case (mode)
      MODE_PRE: begin
        if (cnt_en && !frozen) begin
          lo_d[PRE_W-1:0] = pre_sum[PRE_W-1:0];
          if (pre_sum[PRE_W]) begin
            hi_d    = hi_sum[BYTE_W-1:0];
            ovf_own = hi_sum[BYTE_W];
          end
        end
      end
      MODE_CAS: begin
        if (cnt_en && !frozen) begin
          {hi_d, lo_d} = wide_sum[WIDE_W-1:0];
          ovf_own      = wide_sum[WIDE_W];
        end
      end
      MODE_RLD: begin
        if (cnt_en && !frozen) begin
          if (lo_sum[BYTE_W]) begin
            lo_d    = hi_q;
            ovf_own = 1'b1;
          end else begin
            lo_d = lo_sum[BYTE_W-1:0];
          end
        end
      end
      MODE_SPL: begin
        if (SPLIT_OK) begin
          if (cnt_en && !wr_lo) begin
            lo_d    = lo_sum[BYTE_W-1:0];
            ovf_own = lo_sum[BYTE_W];
          end
          if (hi_en && !wr_hi) begin
            hi_d    = hi_sum[BYTE_W-1:0];
            ovf_alt = hi_sum[BYTE_W];
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R2: no enable and no write means both bytes hold
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !hi_en && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

  // R5: low byte takes the high byte on reload
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RLD && cnt_en && !wr_lo && !wr_hi && (&lo_q)) |=> (lo_q == $past(hi_q)));

  // R9: written byte lands regardless of counting
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wr_data)));
endmodule

// File: rtl/dtu_cfg.sv
module dtu_cfg
  import dtu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        set_flag,
  input  logic [1:0]        flag_ack,
  output chan_cfg_t [1:0]   cfg_o
);
  localparam int unsigned HALF = BYTE_W / 2;

  chan_cfg_t [1:0] cfg_q, cfg_d;
  logic mode_wr, aux_wr, ctrl_wr;
  logic unused_bits;

  assign unused_bits = wr_data[BYTE_W-2];
  assign mode_wr = wr_en && (wr_addr == ADDR_W'(ADR_MODE));
  assign aux_wr  = wr_en && (wr_addr == ADDR_W'(ADR_AUX));
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));

  always_comb begin
    cfg_d = cfg_q;
    if (mode_wr) begin
      cfg_d[0].mode[1:0] = wr_data[1:0];
      cfg_d[0].gate      = wr_data[HALF-1];
      cfg_d[1].mode[1:0] = wr_data[HALF+1:HALF];
      cfg_d[1].gate      = wr_data[BYTE_W-1];
    end
    if (aux_wr) begin
      cfg_d[0].mode[2] = wr_data[0];
      cfg_d[1].mode[2] = wr_data[HALF];
    end
    for (int c = 0; c < 2; c++) begin
      if (ctrl_wr) cfg_d[c].run = wr_data[c];
      if (set_flag[c])      cfg_d[c].flag = 1'b1;
      else if (ctrl_wr)     cfg_d[c].flag = wr_data[2+c];
      else if (flag_ack[c]) cfg_d[c].flag = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R8: overflow beats any clear
  a_r8_set_wins0: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag[0] |=> cfg_q[0].flag);
  a_r8_set_wins1: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag[1] |=> cfg_q[1].flag);
  // R8: acknowledge clears when nothing competes
  a_r8_ack_clears0: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ack[0] && !set_flag[0] && !ctrl_wr) |=> !cfg_q[0].flag);
  // R7: reserved codes never raise a flag
  a_r7_reserved_quiet0: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0].mode[2] && !cfg_q[0].flag && !ctrl_wr) |=> !cfg_q[0].flag);
  a_r7_reserved_quiet1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1].mode[2] && cfg_q[0].mode != MODE_SPL && !cfg_q[1].flag && !ctrl_wr)
      |=> !cfg_q[1].flag);
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic [1:0]        gate_in,
  input  logic [1:0]        flag_ack,
  output logic [1:0]        ovf_flag
);
  localparam int unsigned HALF = BYTE_W / 2;

  logic [1:0]             rst_sync;
  logic                   rst_i_n;
  chan_cfg_t [1:0]        cfg;
  logic [1:0]             chan_en, cnt_en, hi_en, wr_lo, wr_hi, ovf_own, ovf_alt, set_flag;
  logic [1:0][BYTE_W-1:0] lo_v, hi_v;
  logic                   split_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign split_on = (cfg[0].mode == MODE_SPL);

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      chan_en[c] = tick && cfg[c].run && (!cfg[c].gate || gate_in[c]);
    end
    cnt_en[0] = chan_en[0];
    cnt_en[1] = chan_en[1] && !split_on;
    hi_en[0]  = tick && cfg[1].run;
    hi_en[1]  = 1'b0;
    set_flag[0] = ovf_own[0] | ovf_alt[1];
    set_flag[1] = ovf_own[1] | ovf_alt[0];
  end

  dtu_cfg #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (reg_we),
    .wr_addr  (reg_waddr),
    .wr_data  (reg_wdata),
    .set_flag (set_flag),
    .flag_ack (flag_ack),
    .cfg_o    (cfg)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign wr_lo[c] = reg_we && (reg_waddr == ADDR_W'(2*c));
    assign wr_hi[c] = reg_we && (reg_waddr == ADDR_W'(2*c+1));

    dtu_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_OK(c == 0)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .mode    (cfg[c].mode),
      .cnt_en  (cnt_en[c]),
      .hi_en   (hi_en[c]),
      .wr_lo   (wr_lo[c]),
      .wr_hi   (wr_hi[c]),
      .wr_data (reg_wdata),
      .lo_o    (lo_v[c]),
      .hi_o    (hi_v[c]),
      .ovf_own (ovf_own[c]),
      .ovf_alt (ovf_alt[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      ADDR_W'(ADR_LO0): reg_rdata = lo_v[0];
      ADDR_W'(ADR_HI0): reg_rdata = hi_v[0];
      ADDR_W'(ADR_LO1): reg_rdata = lo_v[1];
      ADDR_W'(ADR_HI1): reg_rdata = hi_v[1];
      ADDR_W'(ADR_MODE): begin
        reg_rdata[1:0]           = cfg[0].mode[1:0];
        reg_rdata[HALF-1]        = cfg[0].gate;
        reg_rdata[HALF+1:HALF]   = cfg[1].mode[1:0];
        reg_rdata[BYTE_W-1]      = cfg[1].gate;
      end
      ADDR_W'(ADR_AUX): begin
        reg_rdata[0]    = cfg[0].mode[2];
        reg_rdata[HALF] = cfg[1].mode[2];
      end
      ADDR_W'(ADR_CTRL): begin
        reg_rdata[0] = cfg[0].run;
        reg_rdata[1] = cfg[1].run;
        reg_rdata[2] = cfg[0].flag;
        reg_rdata[3] = cfg[1].flag;
      end
      default: ;
    endcase
  end

  assign ovf_flag = {cfg[1].flag, cfg[0].flag};

  // R6: channel 1 stands still while channel 0 is split
  a_r6_ch1_frozen: assert property (@(posedge clk) disable iff (!rst_i_n)
    (split_on && !wr_lo[1] && !wr_hi[1]) |=> ($stable(lo_v[1]) && $stable(hi_v[1])));

  // R11: raising run alone leaves counts intact
  a_r11_run_keeps: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_we && reg_waddr == ADDR_W'(ADR_CTRL) && !tick) |=> ($stable(lo_v) && $stable(hi_v)));
endmodule

// File: tb/test_dual_timer_unit.sv
module test_dual_timer_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tick;
  logic [1:0] gate_in, flag_ack, ovf_flag;

  always #4 clk = ~clk;

  dual_timer_unit i_dual_timer_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tick(tick), .gate_in(gate_in), .flag_ack(flag_ack), .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0, cyc_n = 0;
  string phase = "R1";
  int m_lo[2], m_hi[2], m_mode[2], m_gate[2], m_run[2], m_flag[2];

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0; m_mode[c] = 0; m_gate[c] = 0; m_run[c] = 0; m_flag[c] = 0;
      end
    end else begin
      int d; bit wl[2]; bit wh[2]; bit en[2]; bit s[2]; int nlo[2]; int nhi[2];
      d = reg_wdata;
      for (int c = 0; c < 2; c++) begin
        wl[c] = reg_we && reg_waddr == 2*c;
        wh[c] = reg_we && reg_waddr == 2*c + 1;
        en[c] = tick && m_run[c] != 0 && (m_gate[c] == 0 || gate_in[c]);
        s[c] = 0; nlo[c] = m_lo[c]; nhi[c] = m_hi[c];
      end
      for (int c = 0; c < 2; c++) begin
        bit go;
        go = en[c] && !(c == 1 && m_mode[0] == 3);
        if (c == 0 && m_mode[0] == 3) begin
          if (go && !wl[0]) begin
            nlo[0] = (m_lo[0] + 1) % 256;
            if (m_lo[0] == 255) s[0] = 1;
          end
          if (tick && m_run[1] != 0 && !wh[0]) begin
            nhi[0] = (m_hi[0] + 1) % 256;
            if (m_hi[0] == 255) s[1] = 1;
          end
        end else if (go && !wl[c] && !wh[c]) begin
          if (m_mode[c] == 0) begin
            int p; p = (m_lo[c] % 32) + 1;
            if (p == 32) begin
              p = 0; nhi[c] = (m_hi[c] + 1) % 256;
              if (m_hi[c] == 255) s[c] = 1;
            end
            nlo[c] = (m_lo[c] / 32) * 32 + p;
          end else if (m_mode[c] == 1) begin
            int v; v = m_hi[c] * 256 + m_lo[c] + 1;
            if (v == 65536) begin v = 0; s[c] = 1; end
            nhi[c] = v / 256; nlo[c] = v % 256;
          end else if (m_mode[c] == 2) begin
            if (m_lo[c] == 255) begin nlo[c] = m_hi[c]; s[c] = 1; end
            else nlo[c] = m_lo[c] + 1;
          end
        end
        if (wl[c]) nlo[c] = d;
        if (wh[c]) nhi[c] = d;
      end
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = nlo[c]; m_hi[c] = nhi[c];
        if (s[c]) m_flag[c] = 1;
        else if (reg_we && reg_waddr == 6) m_flag[c] = (d >> (2 + c)) & 1;
        else if (flag_ack[c]) m_flag[c] = 0;
      end
      if (reg_we && reg_waddr == 4) begin
        m_mode[0] = (m_mode[0] & 4) | (d & 3); m_gate[0] = (d >> 3) & 1;
        m_mode[1] = (m_mode[1] & 4) | ((d >> 4) & 3); m_gate[1] = (d >> 7) & 1;
      end
      if (reg_we && reg_waddr == 5) begin
        m_mode[0] = (m_mode[0] & 3) | ((d & 1) << 2);
        m_mode[1] = (m_mode[1] & 3) | (((d >> 4) & 1) << 2);
      end
      if (reg_we && reg_waddr == 6) begin
        m_run[0] = d & 1; m_run[1] = (d >> 1) & 1;
      end
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_lo[0];
      1: return m_hi[0];
      2: return m_lo[1];
      3: return m_hi[1];
      4: return (m_gate[1] << 7) | ((m_mode[1] & 3) << 4) | (m_gate[0] << 3) | (m_mode[0] & 3);
      5: return ((m_mode[1] >> 2) << 4) | (m_mode[0] >> 2);
      6: return m_run[0] | (m_run[1] << 1) | (m_flag[0] << 2) | (m_flag[1] << 3);
      default: return 0;
    endcase
  endfunction

  // one cycle: compare after the last edge, then drive the next inputs
  task automatic cyc(bit we, int a, int d, bit tk, bit [1:0] gi, bit [1:0] ak);
    int ra, expf;
    @(negedge clk);
    ra = cyc_n % 8;
    cyc_n++;
    reg_raddr = 3'(ra);
    #1;
    n_chk++;
    if (int'(reg_rdata) != exp_rd(ra)) begin
      n_fail++;
      $display("FAIL %s addr %0d read %0h expected %0h", phase, ra, reg_rdata, exp_rd(ra));
    end
    expf = (m_flag[1] << 1) | m_flag[0];
    n_chk++;
    if (int'(ovf_flag) != expf) begin
      n_fail++;
      $display("FAIL %s ovf_flag %0b expected %0b", phase, ovf_flag, expf);
    end
    reg_we = we; reg_waddr = 3'(a); reg_wdata = 8'(d);
    tick = tk; gate_in = gi; flag_ack = ak;
  endtask

  task automatic wr(int a, int d);
    cyc(1'b1, a, d, 1'b0, 2'b00, 2'b00);
  endtask

  function automatic int pick_data();
    case ($urandom % 6)
      0: return 8'hFF;
      1: return 8'hFE;
      2: return 8'h1F;
      3: return 8'hFD;
      default: return $urandom % 256;
    endcase
  endfunction

  task automatic run_rand(int n, int wmax, int wdiv, int tick_pct, int ack_div);
    for (int i = 0; i < n; i++) begin
      bit we; int a;
      we = ($urandom % wdiv) == 0;
      a  = $urandom % wmax;
      cyc(we, a, pick_data(), ($urandom % 100) < tick_pct, 2'($urandom),
          {($urandom % ack_div) == 0, ($urandom % ack_div) == 0});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_waddr = 0; reg_wdata = 0; reg_raddr = 0;
    tick = 0; gate_in = 0; flag_ack = 0;
    // R1: reset state of every register and both flag pins
    phase = "R1";
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 0);

    // R10: register map write and read back
    phase = "R10";
    wr(4, 8'hA5); wr(5, 8'h11); wr(6, 8'h0C); wr(7, 8'h77);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0);
    wr(5, 0); wr(6, 0); wr(4, 0);

    // R3: 13-bit prescaled count across the top, upper low bits kept
    phase = "R3";
    wr(1, 8'hFF); wr(0, 8'hE0 | 8'h1B); wr(6, 1);
    for (int i = 0; i < 80; i++) cyc(0, 0, 0, 1, 0, 0);

    // R2: gate and run control the advance
    phase = "R2";
    wr(4, 8'h89); wr(6, 3); wr(0, 8'hF0); wr(2, 8'hF0);
    run_rand(300, 4, 40, 70, 50);
    wr(6, 0);
    run_rand(50, 4, 1000, 100, 1000);

    // R4: 16-bit wrap on both channels
    phase = "R4";
    wr(4, 8'h11); wr(1, 8'hFF); wr(0, 8'hF8); wr(3, 8'hFF); wr(2, 8'hFA); wr(6, 3);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 0, 0);

    // R5: auto reload from the high byte
    phase = "R5";
    wr(4, 8'h22); wr(1, 8'hF0); wr(0, 8'hFC); wr(3, 8'h80); wr(2, 8'hF8); wr(6, 3);
    for (int i = 0; i < 120; i++) cyc(0, 0, 0, 1, 0, 0);

    // R6: split channel 0, channel 1 frozen, high byte feeds flag 1
    phase = "R6";
    wr(6, 0); wr(4, 8'h13); wr(1, 8'hFC); wr(0, 8'hFD); wr(2, 8'h55); wr(6, 3);
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 0, 0);
    run_rand(600, 4, 30, 80, 20);
    wr(4, 8'h33);
    run_rand(200, 4, 30, 80, 20);

    // R7: reserved codes including the 110 code hold and stay quiet
    phase = "R7";
    wr(6, 0); wr(5, 8'h11); wr(4, 8'h20);
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); wr(6, 3);
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 2'b11, 0);
    wr(5, 0);

    // R8: flag clear by write and by ack, overflow winning a race
    phase = "R8";
    wr(4, 8'h22); wr(1, 8'hFE); wr(0, 8'hFE); wr(6, 1);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 2'b01);
    cyc(0, 0, 0, 0, 0, 2'b01);
    cyc(0, 0, 0, 0, 0, 0);
    wr(0, 8'hFF);
    cyc(1, 6, 8'h01, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    wr(6, 8'h01);
    run_rand(400, 4, 10, 90, 6);

    // R9: writes racing the increment in every mode
    phase = "R9";
    wr(4, 8'h01); wr(6, 3);
    run_rand(300, 4, 2, 100, 30);
    wr(4, 8'h20);
    run_rand(300, 4, 2, 100, 30);
    wr(4, 8'h03);
    run_rand(300, 4, 2, 100, 30);

    // R11: setting run does not touch the counts
    phase = "R11";
    wr(6, 0); wr(4, 8'h11); wr(0, 8'h3C); wr(1, 8'hA7); wr(2, 8'h5A); wr(3, 8'h81);
    wr(6, 3);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0);

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: mixed modes under load
    phase = "R10-mix";
    run_rand(20000, 8, 6, 75, 25);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule